// File: doc/BRIEF.md
# Programmable Static Memory Timing Sequencer

This block runs one access to an external static memory at a time and drives the chip select, output enable, write enable and active-low byte-lane masks for it. A single-cycle start pulse carries the address, the direction, the write data, the byte enables, two mode bits and a 32-bit timing word. The block captures all of these when the pulse is accepted, so later changes on those inputs do not affect the access in flight.

The timing word holds seven 4-bit phase fields. Each field has its own offset encoding. Write accesses use an address setup phase, a write-enable pulse inside a fixed total access window, and an idle gap. Read accesses use an address setup phase, a total access window whose last cycle captures the read data, and an idle gap. After the idle gap the block pulses done and accepts the next start.

Before an access begins, the block checks each field code and the relations between the fields. A bad setting raises a one-cycle error pulse and the access does not run. One mode bit moves the write strobe from write enable to the byte masks. The other chooses whether byte masks apply on reads.

Top module: `smem_seq`

## Requirements
- R1: Timing word layout: bits [3:0] write setup (code+1 cycles), [7:4] write strobe (code+1), [11:8] write total (code+1), [15:12] write idle (code+1), [19:16] read setup (code cycles), [23:20] read total (code+1), [27:24] read idle (code+1), [31:28] unused. For a write, memCsN is low for the write total starting in the cycle after the start edge. memAddr, memWdata and memDriveEn=1 hold through that window. The timing word, address, data, masks and mode bits are captured at start.
- R2: On a write with weOffMode=0, memWeN is low for exactly the write strobe count of cycles, beginning right after the write setup count of cycles of the access.
- R3: For a read, memCsN is low for the read total. memOeN goes low once the read setup count of cycles has passed and stays low until the window ends. A setup code of 0 makes memOeN fall together with memCsN. memWeN stays high and memDriveEn stays 0.
- R4: rdCapture is high only in the last cycle of a read access window. rdData then holds the memRdata value of that cycle.
- R5: After the access window, memCsN stays high for the idle count of cycles. Then done is high for one cycle with busy low. A start while busy is ignored.
- R6: With weOffMode=1 (captured at start), memWeN stays high for the whole write. The enabled byte lanes of memMaskN go low only during the write strobe cycles.
- R7: On a write with weOffMode=0, memMaskN equals the inverted byte enables (startMask bit i enables lane i) for the whole access window.
- R8: On a read, memMaskN equals the inverted byte enables when readMaskMode=1. It is all zeros (every lane enabled) when readMaskMode=0.
- R9: For a write, a write setup code of 15, a write strobe code of 15, or a write total code below 2 produces a one-cycle cfgError in the cycle after the start edge. No chip select, no done and no busy follow.
- R10: A write whose total cycles are fewer than setup cycles plus strobe cycles, or a read whose setup code exceeds its total code, is rejected as in R9. The write fields do not affect a read.
- R11: In reset and outside an access, memCsN, memOeN and memWeN are high, memMaskN is all ones, and memDriveEn, busy, done, cfgError and rdCapture are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request pulse |
| startWrite | input | 1 | 1 = write, 0 = read |
| startAddr | input | ADDR_W | Access address |
| startWdata | input | DATA_W | Write data |
| startMask | input | DATA_W/8 | Byte-lane enables, active high |
| timingCfg | input | 32 | Phase length fields |
| weOffMode | input | 1 | Use byte masks as the write strobe |
| readMaskMode | input | 1 | Apply byte masks on reads |
| busy | output | 1 | Access or idle gap in progress |
| done | output | 1 | One-cycle completion pulse |
| cfgError | output | 1 | One-cycle rejected-start pulse |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memMaskN | output | DATA_W/8 | Byte-lane masks, active low |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memDriveEn | output | 1 | Data bus output enable |
| memRdata | input | DATA_W | Memory read data |
| rdCapture | output | 1 | Read data sample strobe |
| rdData | output | DATA_W | Captured read data |

## Verification
Random timing words are built to satisfy every field relation. Each is driven through writes and reads, and every pin is compared cycle by cycle with the phase boundaries that the field codes predict. Off-by-one errors in any single encoding therefore show up as a shifted edge. Directed cases cover the tight edges: a write total exactly equal to setup plus strobe, a read setup equal to its total so output enable lasts one cycle, and a zero read setup. They also run both mode bits at both values, which tells the strobe-on-mask path apart from the write-enable path. Each invalid code and each broken relation is tried on its own. A read carrying invalid write fields is also tried. A start during an access and input changes after a start show that the captured settings, not the live inputs, drive the access.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int FIELD_W = 4;
  localparam int CNT_W   = FIELD_W + 1;

  typedef struct packed {
    logic [FIELD_W-1:0] spare;
    logic [FIELD_W-1:0] rdIdle;
    logic [FIELD_W-1:0] rdAccess;
    logic [FIELD_W-1:0] rdSetup;
    logic [FIELD_W-1:0] wrIdle;
    logic [FIELD_W-1:0] wrTotal;
    logic [FIELD_W-1:0] wrStrobe;
    logic [FIELD_W-1:0] wrSetup;
  } timing_t;

  localparam timing_t TIMING_RESET = '{
    spare:    4'h0,
    rdIdle:   4'hF,
    rdAccess: 4'hF,
    rdSetup:  4'h0,
    wrIdle:   4'h0,
    wrTotal:  4'hF,
    wrStrobe: 4'h5,
    wrSetup:  4'h5
  };

  typedef enum logic [1:0] {
    ST_READY,
    ST_ACCESS,
    ST_RECOVER
  } seq_state_t;

  typedef struct packed {
    logic load;
    logic csActive;
    logic oeActive;
    logic weWindow;
    logic capture;
    logic isWrite;
  } strobe_t;

  function automatic logic cfgBad(timing_t t, logic isWr);
    logic [CNT_W:0] totalCyc;
    logic [CNT_W:0] needCyc;
    logic bad;
    totalCyc = {2'b00, t.wrTotal} + 6'd1;
    needCyc  = {2'b00, t.wrSetup} + {2'b00, t.wrStrobe} + 6'd2;
    if (isWr) begin
      bad = (t.wrSetup == 4'hF) || (t.wrStrobe == 4'hF) ||
            (t.wrTotal < 4'd2) || (totalCyc < needCyc);
    end else begin
      bad = (t.rdSetup > t.rdAccess);
    end
    return bad;
  endfunction

endpackage

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    startWrite,
  input  timing_t timingIn,
  output logic    busy,
  output logic    done,
  output logic    cfgError,
  output strobe_t strb
);

  seq_state_t state;
  logic [CNT_W-1:0] cnt;
  timing_t cfgQ;
  logic wrQ;
  logic doneQ;
  logic errQ;

  logic accept;
  logic bad;
  logic [CNT_W-1:0] accessLast;
  logic [CNT_W-1:0] idleLast;
  logic [CNT_W-1:0] weStart;
  logic [CNT_W-1:0] weEnd;
  logic [CNT_W-1:0] oeStart;
  logic inAccess;

  assign accept = start && (state == ST_READY);
  assign bad    = cfgBad(timingIn, startWrite);

  assign accessLast = wrQ ? {1'b0, cfgQ.wrTotal} : {1'b0, cfgQ.rdAccess};
  assign idleLast   = wrQ ? {1'b0, cfgQ.wrIdle}  : {1'b0, cfgQ.rdIdle};
  assign weStart    = {1'b0, cfgQ.wrSetup} + 5'd1;
  assign weEnd      = weStart + {1'b0, cfgQ.wrStrobe} + 5'd1;
  assign oeStart    = {1'b0, cfgQ.rdSetup};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_READY;
      cnt   <= '0;
      cfgQ  <= TIMING_RESET;
      wrQ   <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      case (state)
        ST_READY: begin
          if (accept) begin
            if (bad) begin
              errQ <= 1'b1;
            end else begin
              state <= ST_ACCESS;
              cnt   <= '0;
              cfgQ  <= timingIn;
              wrQ   <= startWrite;
            end
          end
        end
        ST_ACCESS: begin
          if (cnt == accessLast) begin
            state <= ST_RECOVER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        ST_RECOVER: begin
          if (cnt == idleLast) begin
            state <= ST_READY;
            cnt   <= '0;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        default: state <= ST_READY;
      endcase
    end
  end

  assign inAccess = (state == ST_ACCESS);

  always_comb begin
    strb.load     = accept && !bad;
    strb.csActive = inAccess;
    strb.oeActive = inAccess && !wrQ && (cnt >= oeStart);
    strb.weWindow = inAccess && wrQ && (cnt >= weStart) && (cnt < weEnd);
    strb.capture  = inAccess && !wrQ && (cnt == accessLast);
    strb.isWrite  = wrQ;
  end

  assign busy     = (state != ST_READY);
  assign done     = doneQ;
  assign cfgError = errQ;

endmodule

// File: rtl/smem_dpath.sv
module smem_dpath
  import smem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startWdata,
  input  logic [MASK_W-1:0] startMask,
  input  logic              weOffMode,
  input  logic              readMaskMode,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [MASK_W-1:0] memMaskN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memDriveEn,
  output logic              rdCapture,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [MASK_W-1:0] maskQ;
  logic              weOffQ;
  logic              rdMaskQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      maskQ   <= '0;
      weOffQ  <= 1'b0;
      rdMaskQ <= 1'b0;
    end else if (strb.load) begin
      addrQ   <= startAddr;
      wdataQ  <= startWdata;
      maskQ   <= startMask;
      weOffQ  <= weOffMode;
      rdMaskQ <= readMaskMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strb.capture) begin
      rdDataQ <= memRdata;
    end
  end

  always_comb begin
    if (!strb.csActive) begin
      memMaskN = '1;
    end else if (strb.isWrite) begin
      if (weOffQ) begin
        memMaskN = strb.weWindow ? ~maskQ : '1;
      end else begin
        memMaskN = ~maskQ;
      end
    end else begin
      memMaskN = rdMaskQ ? ~maskQ : '0;
    end
  end

  assign memCsN     = !strb.csActive;
  assign memOeN     = !strb.oeActive;
  assign memWeN     = !(strb.weWindow && !weOffQ);
  assign memAddr    = addrQ;
  assign memWdata   = wdataQ;
  assign memDriveEn = strb.csActive && strb.isWrite;
  assign rdCapture  = strb.capture;
  assign rdData     = rdDataQ;

endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              startWrite,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startWdata,
  input  logic [MASK_W-1:0] startMask,
  input  logic [31:0]       timingCfg,
  input  logic              weOffMode,
  input  logic              readMaskMode,
  output logic              busy,
  output logic              done,
  output logic              cfgError,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [MASK_W-1:0] memMaskN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memDriveEn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rdCapture,
  output logic [DATA_W-1:0] rdData
);

  strobe_t strb;
  timing_t timingIn;

  assign timingIn = timing_t'(timingCfg);

  smem_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .startWrite (startWrite),
    .timingIn   (timingIn),
    .busy       (busy),
    .done       (done),
    .cfgError   (cfgError),
    .strb       (strb)
  );

  smem_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .startAddr    (startAddr),
    .startWdata   (startWdata),
    .startMask    (startMask),
    .weOffMode    (weOffMode),
    .readMaskMode (readMaskMode),
    .memRdata     (memRdata),
    .memCsN       (memCsN),
    .memOeN       (memOeN),
    .memWeN       (memWeN),
    .memMaskN     (memMaskN),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memDriveEn   (memDriveEn),
    .rdCapture    (rdCapture),
    .rdData       (rdData)
  );

endmodule

// File: rtl/smem_seq_chk.sv
module smem_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int MASK_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cfgError,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [MASK_W-1:0] memMaskN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memDriveEn,
  input logic              rdCapture
);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> (memOeN && memWeN && (memMaskN == '1) && !memDriveEn && !rdCapture));

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> ($stable(memAddr) && $stable(memWdata)));

  assert_oe_read_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDriveEn && memWeN));

  assert_we_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDriveEn && !memCsN));

  assert_capture_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdCapture |-> (!memOeN && !memCsN));

  assert_err_no_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (memCsN && !busy && !done));

  assert_done_after_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && memCsN && $past(memCsN)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind smem_seq smem_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .cfgError   (cfgError),
  .memCsN     (memCsN),
  .memOeN     (memOeN),
  .memWeN     (memWeN),
  .memMaskN   (memMaskN),
  .memAddr    (memAddr),
  .memWdata   (memWdata),
  .memDriveEn (memDriveEn),
  .rdCapture  (rdCapture)
);

// File: tb/tb_smem_seq.sv
`timescale 1ns/100ps
module tb_smem_seq;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int MASK_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic startWrite = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [DATA_W-1:0] startWdata = '0;
  logic [MASK_W-1:0] startMask = '0;
  logic [31:0] timingCfg = '0;
  logic weOffMode = 1'b0;
  logic readMaskMode = 1'b0;
  logic busy, done, cfgError;
  logic memCsN, memOeN, memWeN, memDriveEn, rdCapture;
  logic [MASK_W-1:0] memMaskN;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rdPat(input int k, input logic [23:0] a);
    return 16'hA53C ^ a[15:0] ^ (16'(k) * 16'h0111);
  endfunction

  function automatic logic [31:0] mkCfg(input int ws, input int ww, input int wt,
                                        input int wi, input int rs, input int ra,
                                        input int ri);
    return {4'h0, 4'(ri), 4'(ra), 4'(rs), 4'(wi), 4'(wt), 4'(ww), 4'(ws)};
  endfunction

  task automatic runAccess(input logic wr, input logic [23:0] a, input logic [15:0] d,
                           input logic [1:0] m, input logic [31:0] cfg,
                           input logic wo, input logic rm, input bit intrude);
    int nAcc, nIdle, sCyc, wCyc, rSet;
    logic expWe, expOe;
    logic [1:0] expMask;
    logic [15:0] expRd;
    sCyc  = int'(cfg[3:0]) + 1;
    wCyc  = int'(cfg[7:4]) + 1;
    rSet  = int'(cfg[19:16]);
    nAcc  = wr ? int'(cfg[11:8]) + 1 : int'(cfg[23:20]) + 1;
    nIdle = wr ? int'(cfg[15:12]) + 1 : int'(cfg[27:24]) + 1;
    expRd = '0;
    @(negedge clk);
    start = 1'b1; startWrite = wr; startAddr = a; startWdata = d; startMask = m;
    timingCfg = cfg; weOffMode = wo; readMaskMode = rm;
    @(negedge clk);
    start = 1'b0; startAddr = ~a; startWdata = ~d; startMask = ~m;
    timingCfg = 32'h0000_0000; weOffMode = ~wo; readMaskMode = ~rm;
    startWrite = ~wr;
    for (int k = 0; k <= nAcc + nIdle; k++) begin
      if (k > 0) @(negedge clk);
      memRdata = rdPat(k, a);
      if (intrude && k == 1) begin
        start = 1'b1; startAddr = a ^ 24'h00FF00; timingCfg = cfg;
      end
      if (intrude && k == 2) start = 1'b0;
      if (k < nAcc) begin
        if (k == nAcc - 1 && !wr) expRd = rdPat(k, a);
        if (wr) begin
          expWe   = (k >= sCyc) && (k < sCyc + wCyc);
          expMask = wo ? (expWe ? ~m : 2'b11) : ~m;
          check("R1", "csN write", {31'b0, memCsN}, 32'd0);
          check("R1", "addr write", {8'b0, memAddr}, {8'b0, a});
          check("R1", "wdata", {16'b0, memWdata}, {16'b0, d});
          check("R1", "driveEn", {31'b0, memDriveEn}, 32'd1);
          check(wo ? "R6" : "R2", "weN", {31'b0, memWeN}, {31'b0, !(expWe && !wo)});
          check(wo ? "R6" : "R7", "maskN write", {30'b0, memMaskN}, {30'b0, expMask});
          check("R3", "oeN on write", {31'b0, memOeN}, 32'd1);
        end else begin
          expOe = (k >= rSet);
          check("R3", "csN read", {31'b0, memCsN}, 32'd0);
          check("R3", "oeN", {31'b0, memOeN}, {31'b0, !expOe});
          check("R3", "weN on read", {31'b0, memWeN}, 32'd1);
          check("R3", "driveEn read", {31'b0, memDriveEn}, 32'd0);
          check("R8", "maskN read", {30'b0, memMaskN}, {30'b0, (rm ? ~m : 2'b00)});
          check("R4", "rdCapture", {31'b0, rdCapture}, {31'b0, (k == nAcc - 1)});
          check("R1", "addr read", {8'b0, memAddr}, {8'b0, a});
        end
        check("R5", "busy in access", {31'b0, busy}, 32'd1);
      end else if (k < nAcc + nIdle) begin
        check("R5", "csN idle", {31'b0, memCsN}, 32'd1);
        check("R11", "strobes idle", {28'b0, memOeN, memWeN, memMaskN}, 32'hF);
        check("R5", "done early", {31'b0, done}, 32'd0);
        check("R5", "busy idle", {31'b0, busy}, 32'd1);
      end else begin
        check("R5", "done", {31'b0, done}, 32'd1);
        check("R5", "busy at done", {31'b0, busy}, 32'd0);
        check("R11", "csN at done", {31'b0, memCsN}, 32'd1);
        if (!wr) check("R4", "rdData", {16'b0, rdData}, {16'b0, expRd});
      end
    end
  endtask

  task automatic runBad(input string req, input logic wr, input logic [31:0] cfg);
    @(negedge clk);
    start = 1'b1; startWrite = wr; timingCfg = cfg; startAddr = 24'h123456;
    @(negedge clk);
    start = 1'b0;
    check(req, "cfgError", {31'b0, cfgError}, 32'd1);
    check(req, "csN on reject", {31'b0, memCsN}, 32'd1);
    check(req, "busy on reject", {31'b0, busy}, 32'd0);
    @(negedge clk);
    check(req, "cfgError clears", {31'b0, cfgError}, 32'd0);
    check(req, "no access", {30'b0, memCsN, busy}, 32'd2);
    check(req, "no done", {31'b0, done}, 32'd0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset strobes", {27'b0, memCsN, memOeN, memWeN, memMaskN}, 32'h1F);
    check("R11", "reset flags", {27'b0, busy, done, cfgError, memDriveEn, rdCapture}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "post-reset strobes", {27'b0, memCsN, memOeN, memWeN, memMaskN}, 32'h1F);

    // directed corners
    runAccess(1'b1, 24'h0A0B0C, 16'hBEEF, 2'b11, mkCfg(1, 2, 4, 0, 0, 0, 0), 1'b0, 1'b0, 1'b1); // R2 total == setup+strobe
    runAccess(1'b1, 24'h000100, 16'h1234, 2'b01, mkCfg(0, 1, 5, 2, 0, 0, 0), 1'b1, 1'b0, 1'b0); // R6
    runAccess(1'b0, 24'h00F00F, 16'h0, 2'b10, mkCfg(0, 0, 0, 0, 0, 3, 1), 1'b0, 1'b1, 1'b0);   // R3 setup 0, R8 on
    runAccess(1'b0, 24'h777777, 16'h0, 2'b01, mkCfg(0, 0, 0, 0, 4, 4, 0), 1'b0, 1'b0, 1'b0);   // R3 oe one cycle, R8 off
    runAccess(1'b0, 24'h000001, 16'h0, 2'b11, mkCfg(15, 15, 0, 0, 0, 0, 2), 1'b0, 1'b1, 1'b0); // R10 write fields ignored on read

    // R9 invalid codes, R10 relations
    runBad("R9", 1'b1, mkCfg(15, 0, 15, 0, 0, 0, 0));
    runBad("R9", 1'b1, mkCfg(0, 15, 15, 0, 0, 0, 0));
    runBad("R9", 1'b1, mkCfg(0, 0, 1, 0, 0, 0, 0));
    runBad("R10", 1'b1, mkCfg(3, 3, 6, 0, 0, 0, 0));
    runBad("R10", 1'b0, mkCfg(0, 0, 0, 0, 5, 4, 0));

    // constrained random legal accesses
    for (int i = 0; i < 60; i++) begin
      int ws, ww, lo, wt, ra, rs;
      ws = int'($urandom % 8);
      ww = int'($urandom % (15 - ws));
      lo = (ws + ww + 1 > 2) ? ws + ww + 1 : 2;
      wt = lo + int'($urandom % (16 - lo));
      ra = int'($urandom % 16);
      rs = int'($urandom % (ra + 1));
      runAccess(1'($urandom), 24'($urandom), 16'($urandom), 2'($urandom),
                mkCfg(ws, ww, wt, int'($urandom % 16), rs, ra, int'($urandom % 16)),
                1'($urandom), 1'($urandom), (wt >= 2 && ra >= 2) ? 1'b1 : 1'b0);
    end

    finishRun();
  end

endmodule